// File: doc/BRIEF.md
# Flip-Index Test Slice Decompressor

This block feeds a set of parallel scan chains from one serial test-data pin. It keeps a slice register, with one bit for each chain, and never reloads that register in full. Each new slice is made by inverting chosen bits of the slice that came before it. The serial stream fills a short index shift register. A binary decoder turns the register's value into the address of one slice bit. While the flip enable is high, that bit is inverted on each clock.

Each clock shifts exactly one new bit into the index register. Consecutive flip addresses can therefore share bits: when the flip order is chosen well, one serial bit per flip is enough. A one-cycle commit pulse copies the finished slice onto the chain inputs. The same pulse folds the chains' responses into a signature register. The flip enable shares a bidirectional pin with the response output. A select input decides which of the two the pin carries. In response mode the pin shows the signature bit that the index register addresses, so a tester can read out the signature by shifting in addresses.

Top module: `slice_mutator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the index register, the slice register, the signature and `chainIn` to all zeros.
- R2: On every clock with `sliceDone` low, the index register takes `dataIn` into its most significant bit and moves the other bits one place toward bit 0. For example, from 000 a 1 gives 100, and a following 0 gives 010.
- R3: On a clock with `sliceDone` low, `pinSelect` = 1 and `pinIn` = 1, the slice bit whose position equals the index register's value before that clock's shift is inverted. The slice has 2^IDX_W bits.
- R4: On a clock with `sliceDone` low and either `pinSelect` = 0 or `pinIn` = 0, the slice register keeps its value while the index register still shifts.
- R5: Flips may follow each other on consecutive clocks, each using the address formed by one more shifted bit. For example, index 10 flips bit 2 and shifting in a 1 then forms index 11, which flips bit 3 on the next clock.
- R6: A clock with `sliceDone` high loads `chainIn` (bit j drives chain j) from the slice register. In that clock the slice register and the index register do not change, even if the flip enable is high. The slice is not cleared: the next slice is made by mutating it.
- R7: The signature register changes only on clocks with `sliceDone` high. Its next value is (sig << 1) XOR (sig[MSB] ? TAPS : 0) XOR `scanResp`. For the default 8-bit width, TAPS = 8'h1D (x^8+x^4+x^3+x^2+1).
- R8: With `pinSelect` = 0, `pinOe` = 1 and `pinOut` equals signature bit number (index register value). With `pinSelect` = 1, `pinOe` = 0 and `pinOut` = 0.
- R9: `chainIn` holds its value on every clock without `sliceDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | Serial index stream |
| pinSelect | input | 1 | 1: shared pin carries flip enable; 0: pin carries signature data |
| pinIn | input | 1 | Flip enable as received on the shared pin |
| sliceDone | input | 1 | One-cycle commit of the current slice |
| scanResp | input | 2^IDX_W | Responses from the scan chains |
| chainIn | output | 2^IDX_W | Slice applied to the scan chain inputs |
| pinOut | output | 1 | Signature bit driven onto the shared pin |
| pinOe | output | 1 | Output enable of the shared pin |

## Verification
A sweep writes each of the eight addresses in turn with the enable held low during the fill. This tells a correct decoder and shift direction apart from a reversed or offset one. Chained streams with the enable held high on consecutive clocks check that each flip uses the address before the shift, not the one after it. Commits issued with the enable high show that a commit cycle neither flips nor shifts. A long pseudo-random mix of stream bits, enables, pin modes and responses compares the chain outputs and the pin at every cycle against an arithmetic model. Because response mode reads signature bits at whatever address the index register holds, the same run also exposes errors in the feedback taps or in when the signature updates.

// File: rtl/smut_pkg.sv
package smut_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic doShift;    // move index register, take serial bit
    logic doFlip;     // invert decoded slice bit
    logic doCommit;   // apply slice to chains, clock signature
    logic driveResp;  // shared pin drives signature data
  } strobe_t;

  // Primitive feedback polynomials (without the x^n term) by width
  function automatic logic [31:0] misrTaps(input int width);
    case (width)
      2:       return 32'h0000_0003;
      4:       return 32'h0000_0003;
      8:       return 32'h0000_001D;
      16:      return 32'h0000_100B;
      32:      return 32'h04C1_1DB7;
      default: return 32'h0000_0003;
    endcase
  endfunction

endpackage

// File: rtl/smut_ctrl.sv
module smut_ctrl
  import smut_pkg::*;
(
  input  logic    sliceDone,
  input  logic    pinSelect,
  input  logic    pinIn,
  output strobe_t strobe
);

  logic enableSeen;

  // enable is only meaningful while the shared pin is in enable mode
  assign enableSeen = pinSelect & pinIn;

  always_comb begin
    strobe           = '0;
    strobe.doCommit  = sliceDone;
    strobe.doShift   = ~sliceDone;
    strobe.doFlip    = ~sliceDone & enableSeen;
    strobe.driveResp = ~pinSelect;
  end

endmodule

// File: rtl/smut_datapath.sv
module smut_datapath
  import smut_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int SLICE_W = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic               dataIn,
  input  logic [SLICE_W-1:0] scanResp,
  output logic [SLICE_W-1:0] chainIn,
  output logic               pinData,
  output logic [IDX_W-1:0]   idxQ,
  output logic [SLICE_W-1:0] sliceQ,
  output logic [SLICE_W-1:0] misrQ
);

  localparam logic [31:0]        TAPS_FULL = misrTaps(SLICE_W);
  localparam logic [SLICE_W-1:0] TAPS      = TAPS_FULL[SLICE_W-1:0];

  logic [SLICE_W-1:0] selOneHot;
  logic [SLICE_W-1:0] flipMask;
  logic [SLICE_W-1:0] misrNext;
  logic [IDX_W-1:0]   idxNext;

  // index register: serial bit enters at the top
  assign idxNext = {dataIn, idxQ[IDX_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)                 idxQ <= '0;
    else if (strobe.doShift) idxQ <= idxNext;
  end

  // binary decoder of the pre-shift index
  for (genvar g = 0; g < SLICE_W; g++) begin : g_dec
    assign selOneHot[g] = (idxQ == IDX_W'(g));
  end

  assign flipMask = strobe.doFlip ? selOneHot : '0;

  // slice register: mutated in place
  always_ff @(posedge clk) begin
    if (rst) sliceQ <= '0;
    else     sliceQ <= sliceQ ^ flipMask;
  end

  // parallel chain drive
  always_ff @(posedge clk) begin
    if (rst)                  chainIn <= '0;
    else if (strobe.doCommit) chainIn <= sliceQ;
  end

  // signature compactor
  for (genvar g = 0; g < SLICE_W; g++) begin : g_misr
    if (g == 0) begin : g_lo
      assign misrNext[g] = (misrQ[SLICE_W-1] & TAPS[g]) ^ scanResp[g];
    end else begin : g_hi
      assign misrNext[g] = misrQ[g-1] ^ (misrQ[SLICE_W-1] & TAPS[g]) ^ scanResp[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  misrQ <= '0;
    else if (strobe.doCommit) misrQ <= misrNext;
  end

  // signature bit addressed by the index register
  assign pinData = misrQ[idxQ];

endmodule

// File: rtl/slice_mutator.sv
module slice_mutator
  import smut_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int SLICE_W = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dataIn,
  input  logic               pinSelect,
  input  logic               pinIn,
  input  logic               sliceDone,
  input  logic [SLICE_W-1:0] scanResp,
  output logic [SLICE_W-1:0] chainIn,
  output logic               pinOut,
  output logic               pinOe
);

  strobe_t            strobe;
  logic               pinData;
  logic [IDX_W-1:0]   idxQ;
  logic [SLICE_W-1:0] sliceQ;
  logic [SLICE_W-1:0] misrQ;

  smut_ctrl u_ctrl (
    .sliceDone (sliceDone),
    .pinSelect (pinSelect),
    .pinIn     (pinIn),
    .strobe    (strobe)
  );

  smut_datapath #(.IDX_W(IDX_W), .SLICE_W(SLICE_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .scanResp (scanResp),
    .chainIn  (chainIn),
    .pinData  (pinData),
    .idxQ     (idxQ),
    .sliceQ   (sliceQ),
    .misrQ    (misrQ)
  );

  assign pinOe  = strobe.driveResp;
  assign pinOut = strobe.driveResp & pinData;

endmodule

// File: rtl/slice_mutator_chk.sv
module slice_mutator_chk #(
  parameter int IDX_W   = 3,
  parameter int SLICE_W = 1 << IDX_W
) (
  input logic               clk,
  input logic               rst,
  input logic               dataIn,
  input logic               pinSelect,
  input logic               pinIn,
  input logic               sliceDone,
  input logic [SLICE_W-1:0] chainIn,
  input logic               pinOut,
  input logic               pinOe,
  input logic [IDX_W-1:0]   idxQ,
  input logic [SLICE_W-1:0] sliceQ,
  input logic [SLICE_W-1:0] misrQ
);

  logic seenClk = 1'b0;
  logic pastRst = 1'b0;

  always_ff @(posedge clk) begin
    seenClk <= 1'b1;
    pastRst <= rst;
    if (seenClk && pastRst) begin
      assert_reset_clear_R1: assert (idxQ == '0 && sliceQ == '0 && misrQ == '0 && chainIn == '0)
        else $error("R1 state not cleared by reset");
    end
  end

  assert_index_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !sliceDone |=> idxQ == {$past(dataIn), $past(idxQ[IDX_W-1:1])});

  assert_single_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (!sliceDone && pinSelect && pinIn) |=> $countones(sliceQ ^ $past(sliceQ)) == 1);

  assert_no_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (!sliceDone && !(pinSelect && pinIn)) |=> $stable(sliceQ));

  assert_commit_R6: assert property (@(posedge clk) disable iff (rst)
    sliceDone |=> (chainIn == $past(sliceQ) && $stable(sliceQ) && $stable(idxQ)));

  assert_misr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !sliceDone |=> $stable(misrQ));

  assert_pin_mode_R8: assert property (@(posedge clk) disable iff (rst)
    pinSelect |-> (!pinOe && !pinOut));

  assert_chain_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !sliceDone |=> $stable(chainIn));

endmodule

bind slice_mutator slice_mutator_chk #(.IDX_W(IDX_W), .SLICE_W(SLICE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dataIn    (dataIn),
  .pinSelect (pinSelect),
  .pinIn     (pinIn),
  .sliceDone (sliceDone),
  .chainIn   (chainIn),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .idxQ      (idxQ),
  .sliceQ    (sliceQ),
  .misrQ     (misrQ)
);

// File: tb/sim_slice_mutator.sv
module sim_slice_mutator;
  localparam int K = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         dataIn = 1'b0, pinSelect = 1'b0, pinIn = 1'b0, sliceDone = 1'b0;
  logic [W-1:0] scanResp = '0;
  logic [W-1:0] chainIn;
  logic         pinOut, pinOe;

  slice_mutator u0 (
    .clk(clk), .rst(rst), .dataIn(dataIn), .pinSelect(pinSelect), .pinIn(pinIn),
    .sliceDone(sliceDone), .scanResp(scanResp), .chainIn(chainIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  int checks = 0;
  int errors = 0;

  logic [K-1:0] mIdx   = '0;
  logic [W-1:0] mSlice = '0, mChain = '0, mMisr = '0;

  function automatic logic [W-1:0] misrStep(logic [W-1:0] s, logic [W-1:0] r);
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? 8'h1D : 8'h00) ^ r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkPorts(string tag);
    check({tag, " chainIn"}, chainIn, mChain);
    check({tag, " R8 pinOe"}, {7'd0, pinOe}, {7'd0, ~pinSelect});
    check({tag, " R8 pinOut"}, {7'd0, pinOut}, {7'd0, pinSelect ? 1'b0 : mMisr[mIdx]});
  endtask

  // one clock: drive at negedge, model at posedge, compare 1 ns later
  task automatic step(logic d, logic sel, logic en, logic done, logic [W-1:0] resp, string tag);
    @(negedge clk);
    dataIn = d; pinSelect = sel; pinIn = en; sliceDone = done; scanResp = resp;
    @(posedge clk);
    if (done) begin
      mChain = mSlice;
      mMisr  = misrStep(mMisr, resp);
    end else begin
      if (sel && en) mSlice[mIdx] = ~mSlice[mIdx];
      mIdx = {d, mIdx[K-1:1]};
    end
    #1;
    checkPorts(tag);
  endtask

  task automatic commit(string tag);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    checkPorts("R1 reset");
    check("R1 chainIn zero", chainIn, 8'h00);

    // R2: 000 -1-> 100 -0-> 010, then flip at 010 sets bit 2
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R2 shift a");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R2 shift b");
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R2 R3 flip at 010");
    commit("R6 commit");
    check("R2 bit2 set", chainIn, 8'h04);

    // R6: commit with enable high does not flip or shift, slice kept
    commit("R6 second commit");
    check("R6 slice kept", chainIn, 8'h04);

    // R3/R4 sweep over every index, enable low while filling
    for (int i = 0; i < W; i++) begin
      for (int b = 0; b < K; b++) step(i[b], 1'b1, 1'b0, 1'b0, 8'h00, "R4 fill");
      step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R4 enable in response mode");
      for (int b = 0; b < K; b++) step(i[b], 1'b1, 1'b0, 1'b0, 8'h00, "R4 refill");
      step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R3 flip");
      commit("R3 commit");
      check("R3 sweep", chainIn, mSlice);
    end

    // R5: chained indices, one bit per flip: 01 then 1 -> 10, 11 ...
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R5 fill");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R5 fill");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R5 fill");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 flip");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 flip");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 flip");
    commit("R5 commit");
    check("R5 chained flips", chainIn, mSlice);

    // R7/R8/R9: pseudo-random mix, per-cycle comparison
    lfsr = 8'hA5;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1] | lfsr[6], lfsr[2], (lfsr[5:3] == 3'b101),
           lfsr ^ 8'(n), "R7 R9 random");
    end

    // R1 again: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); mIdx = '0; mSlice = '0; mChain = '0; mMisr = '0;
    @(negedge clk); rst = 1'b0; pinSelect = 1'b0;
    #1;
    checkPorts("R1 mid-run reset");
    commit("R1 post-reset commit");
    check("R1 slice cleared", chainIn, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule